// File: doc/BRIEF.md
# Indirect Configuration Address/Data Port

This block gives software two registers in an 8-byte byte-addressed I/O window. A 32-bit address register selects a target: an enable flag, a bus number, a device slot, a function number and a dword register index. A 32-bit data window then reads or writes that target. Each data-window access either goes out on a downstream configuration port or is answered locally with all ones. The downstream port carries a device index, a dword register index, byte lanes and shifted write data, and it returns the read dword in the same cycle.

The host side presents one access per cycle with `req_i`. Each access carries a write flag, a byte offset into the window, a length in bytes, and write data packed from bit 0. Read results come back one cycle later on `rdata_o`, qualified by `rvalid_o`, with the bytes packed from bit 0. A 32-bit presence vector tells the block which device slots exist. Only bus 0 is served.

Top module: `cfg_addr_data_port`

## Requirements
- R1: After reset the address register is zero, so data-window accesses are disabled; `rvalid_o`, `rdata_o` and `cfg_req_o` are 0.
- R2: When address bit 31 (enable) is 0, data-window reads return all ones and data-window writes raise no `cfg_req_o`.
- R3: A forwarded access drives `cfg_dev_o` from address bits 15:11 and `cfg_reg_o` from bits 7:2. A read uses `cfg_be_o` = 4'hF and returns `cfg_rdata_i`. A write of length L at start s = offset mod 4 drives `cfg_be_o` with lanes s to s+L-1 and `cfg_wdata_o` = write data shifted left by 8*s.
- R4: A data-window access with address bits 23:16 (bus) non-zero reads as all ones and is not forwarded on write.
- R5: A data-window read with address bits 10:8 (function) non-zero returns all ones without a downstream request. A write with a non-zero function is still forwarded.
- R6: An access to a device slot whose bit in `dev_present_i` is 0 is not forwarded; a read returns all ones.
- R7: Writes to offsets 0 to 3 with length 1, 2 or 4 and s+L no more than 4 replace only byte lanes s to s+L-1 of the address register. Any other length, or a write that crosses the dword, leaves it unchanged. Reads and data-window writes never change it.
- R8: A read of length 0, or with s+L greater than 4, returns 32'hFFFFFFFF. Otherwise result byte i (i < L) is byte s+i of the selected dword, little-endian, and the upper bytes are 0. Offsets 8 and above select the all-ones dword.
- R9: `rvalid_o` is 1 exactly in the cycle after a read request. `cfg_req_o` is combinational in the request cycle.
- R10: A data-window write is forwarded only for lengths 1 to 4 with s+L no more than 4. Writes at offsets 8 and above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| off_i | input | OFF_W | Byte offset into the window |
| len_i | input | 3 | Access length in bytes |
| wdata_i | input | 32 | Write data, first byte in bits 7:0 |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data, first byte in bits 7:0 |
| cfg_req_o | output | 1 | Downstream configuration access |
| cfg_we_o | output | 1 | Downstream write flag |
| cfg_dev_o | output | 5 | Device slot index |
| cfg_reg_o | output | 6 | Dword register index |
| cfg_be_o | output | 4 | Byte lanes |
| cfg_wdata_o | output | 32 | Lane-aligned write data |
| cfg_rdata_i | input | 32 | Dword read from the device |
| dev_present_i | input | NUM_DEV | Device slot present flags |

## Verification
Directed sequences build the address register from byte, halfword and full-word writes at each start lane. This separates correct lane merging from whole-word replacement, and the odd-length and crossing cases show the register holding its old value. Separate cases set the enable bit, bus, function and presence one at a time, each on its own, so the all-ones answer can be traced to that one cause. They also show that writes with a non-zero function still go downstream. Random traffic then mixes address updates with reads and writes of every offset and length. A bench device model whose data encodes the device and register catches wrong field slicing and wrong byte extraction.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned LEN_W   = 3;
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned BUS_LSB = 16;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned DEV_LSB = 11;
  localparam int unsigned DEV_W   = 5;
  localparam int unsigned FN_LSB  = 8;
  localparam int unsigned FN_W    = 3;
  localparam int unsigned REG_LSB = 2;
  localparam int unsigned REG_W   = 6;

  function automatic logic fits(input logic [1:0] start, input logic [LEN_W-1:0] len);
    logic [3:0] sum;
    sum = {2'b00, start} + {1'b0, len};
    return (len != '0) && (sum <= 4'd4);
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] start, input logic [LEN_W-1:0] len);
    logic [4:0] m;
    m = (5'd1 << len) - 5'd1;
    return fits(start, len) ? (m[3:0] << start) : 4'h0;
  endfunction
endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg
  import cfgp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    addr_o
);
  localparam int unsigned NB = DW / 8;

  logic          len_ok;
  logic [3:0]    lanes;
  logic [DW-1:0] wsh;

  // only byte, halfword and word sizes may touch the address register
  assign len_ok = (len_i == 3'd1) || (len_i == 3'd2) || (len_i == 3'd4);
  assign lanes  = len_ok ? lane_mask(start_i, len_i) : 4'h0;
  assign wsh    = wdata_i << {start_i, 3'b000};

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 addr_o[8*b +: 8] <= 8'h00;
      else if (wr_i && lanes[b])   addr_o[8*b +: 8] <= wsh[8*b +: 8];
    end
  end

  p_bad_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !len_ok) |=> $stable(addr_o));
endmodule

// File: rtl/cfgp_gate.sv
module cfgp_gate
  import cfgp_pkg::*;
#(
  parameter int unsigned NUM_DEV = 32
) (
  input  logic               win_rd_i,
  input  logic               win_wr_i,
  input  logic [1:0]         start_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [DW-1:0]      addr_i,
  input  logic [NUM_DEV-1:0] dev_present_i,
  output logic               fwd_o,
  output logic               rd_ok_o,
  output logic [DEV_W-1:0]   dev_o,
  output logic [REG_W-1:0]   reg_o
);
  localparam int unsigned SLOTS = 1 << DEV_W;

  logic             en;
  logic [BUS_W-1:0] bus;
  logic [FN_W-1:0]  fn;
  logic [SLOTS-1:0] pres_ext;
  logic             base_ok, len_fit;
  logic [6:0]       unused_addr;

  assign en       = addr_i[EN_BIT];
  assign bus      = addr_i[BUS_LSB +: BUS_W];
  assign dev_o    = addr_i[DEV_LSB +: DEV_W];
  assign fn       = addr_i[FN_LSB +: FN_W];
  assign reg_o    = addr_i[REG_LSB +: REG_W];
  assign unused_addr = {addr_i[30:BUS_LSB+BUS_W], addr_i[1:0]} ^ 7'h0;

  assign pres_ext = SLOTS'(dev_present_i);
  assign len_fit  = fits(start_i, len_i);
  assign base_ok  = en && (bus == '0) && pres_ext[dev_o] && len_fit;
  // function number gates reads only; writes go out regardless
  assign rd_ok_o  = win_rd_i && base_ok && (fn == '0);
  assign fwd_o    = rd_ok_o || (win_wr_i && base_ok);
endmodule

// File: rtl/cfgp_rd_fmt.sv
module cfgp_rd_fmt
  import cfgp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [1:0]       start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DW-1:0]    value_i,
  output logic             rvalid_o,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] shifted, keep, fmt;
  logic [4:0]    m;

  always_comb begin
    shifted = value_i >> {start_i, 3'b000};
    m       = (5'd1 << len_i) - 5'd1;
    for (int b = 0; b < 4; b++) keep[8*b +: 8] = {8{m[b]}};
    fmt     = fits(start_i, len_i) ? (shifted & keep) : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= fmt;
    end
  end

  p_rvalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  p_rvalid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
endmodule

// File: rtl/cfg_addr_data_port.sv
module cfg_addr_data_port
  import cfgp_pkg::*;
#(
  parameter int unsigned OFF_W   = 4,
  parameter int unsigned NUM_DEV = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [DW-1:0]      wdata_i,
  output logic               rvalid_o,
  output logic [DW-1:0]      rdata_o,
  output logic               cfg_req_o,
  output logic               cfg_we_o,
  output logic [DEV_W-1:0]   cfg_dev_o,
  output logic [REG_W-1:0]   cfg_reg_o,
  output logic [3:0]         cfg_be_o,
  output logic [DW-1:0]      cfg_wdata_o,
  input  logic [DW-1:0]      cfg_rdata_i,
  input  logic [NUM_DEV-1:0] dev_present_i
);
  logic          off_hi, sel_addr, sel_data, rd, addr_wr, win_rd, win_wr;
  logic          fwd, rd_ok;
  logic [1:0]    start;
  logic [DW-1:0] addr_q, value;

  assign off_hi   = ((off_i >> 3) != '0);
  assign sel_addr = !off_hi && !off_i[2];
  assign sel_data = !off_hi &&  off_i[2];
  assign start    = off_i[1:0];
  assign rd       = req_i && !we_i;
  assign addr_wr  = req_i &&  we_i && sel_addr;
  assign win_rd   = rd && sel_data;
  assign win_wr   = req_i && we_i && sel_data;

  cfgp_addr_reg i_addr_reg (
    .clk_i, .rst_ni, .wr_i(addr_wr), .start_i(start), .len_i,
    .wdata_i, .addr_o(addr_q)
  );

  cfgp_gate #(.NUM_DEV(NUM_DEV)) i_gate (
    .win_rd_i(win_rd), .win_wr_i(win_wr), .start_i(start), .len_i,
    .addr_i(addr_q), .dev_present_i, .fwd_o(fwd), .rd_ok_o(rd_ok),
    .dev_o(cfg_dev_o), .reg_o(cfg_reg_o)
  );

  assign cfg_req_o   = fwd;
  assign cfg_we_o    = we_i;
  assign cfg_be_o    = we_i ? lane_mask(start, len_i) : 4'hF;
  assign cfg_wdata_o = wdata_i << {start, 3'b000};

  always_comb begin
    if (sel_addr)   value = addr_q;
    else if (rd_ok) value = cfg_rdata_i;
    else            value = '1;
  end

  cfgp_rd_fmt i_rd_fmt (
    .clk_i, .rst_ni, .rd_i(rd), .start_i(start), .len_i,
    .value_i(value), .rvalid_o, .rdata_o
  );

  p_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !addr_q[EN_BIT]) |-> !cfg_req_o);
  p_bus_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (addr_q[BUS_LSB +: BUS_W] != '0)) |-> !cfg_req_o);
  p_fn_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && !cfg_we_o) |-> (addr_q[FN_LSB +: FN_W] == '0));
  p_present_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> dev_present_i[cfg_dev_o]);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(we_i && sel_addr)) |=> $stable(addr_q));
  p_cross_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && ({2'b00, start} + {1'b0, len_i} > 4'd4)) |=> (rdata_o == '1));
  p_lanes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && cfg_we_o) |-> (cfg_be_o != 4'h0));
endmodule

// File: tb/test_cfg_addr_data_port.sv
`timescale 1ns/1ps
module test_cfg_addr_data_port;
  localparam logic [31:0] PRESENT = 32'h5BFF_3F7F; // slot 7 absent

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [3:0] off = 0;
  logic [2:0] len = 0;
  logic [31:0] wdata = 0;
  logic rvalid, cfg_req, cfg_we;
  logic [31:0] rdata, cfg_wdata, cfg_rdata;
  logic [4:0] cfg_dev;
  logic [5:0] cfg_reg;
  logic [3:0] cfg_be;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_addr = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] dev_val(logic [4:0] d, logic [5:0] r);
    return {2'b10, d, r, ~d, r, 8'h5A};
  endfunction
  assign cfg_rdata = dev_val(cfg_dev, cfg_reg);

  cfg_addr_data_port i_cfg_addr_data_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .off_i(off), .len_i(len),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .cfg_req_o(cfg_req),
    .cfg_we_o(cfg_we), .cfg_dev_o(cfg_dev), .cfg_reg_o(cfg_reg), .cfg_be_o(cfg_be),
    .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata), .dev_present_i(PRESENT)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic fit(int s, int l);
    return l != 0 && s + l <= 4;
  endfunction

  function automatic logic [31:0] fmt(logic [31:0] v, int s, int l);
    logic [31:0] r;
    if (!fit(s, l)) return 32'hFFFF_FFFF;
    r = v >> (8 * s);
    for (int b = l; b < 4; b++) r[8*b +: 8] = 8'h00;
    return r;
  endfunction

  function automatic logic [3:0] lanes(int s, int l);
    logic [3:0] m = 0;
    if (!fit(s, l)) return 0;
    for (int b = s; b < s + l; b++) m[b] = 1'b1;
    return m;
  endfunction

  task automatic acc(logic w, logic [3:0] o, logic [2:0] l, logic [31:0] d);
    int s = int'(o[1:0]);
    logic en = m_addr[31], busnz = m_addr[23:16] != 0, fnnz = m_addr[10:8] != 0;
    logic pres = PRESENT[m_addr[15:11]];
    logic data = o[3:2] == 2'b01;
    logic base = en && !busnz && pres && fit(s, int'(l));
    logic exp_fwd = data && base && (w || !fnnz);
    string tag;
    logic [31:0] v, be32;
    if (o >= 8) tag = "R8";
    else if (o < 4) tag = "R7";
    else if (!fit(s, int'(l))) tag = w ? "R10" : "R8";
    else if (!en) tag = "R2";
    else if (busnz) tag = "R4";
    else if (fnnz) tag = "R5";
    else if (!pres) tag = "R6";
    else tag = "R3";
    @(negedge clk);
    req = 1; we = w; off = o; len = l; wdata = d;
    #2;
    chk({tag, " cfg_req"}, 32'(cfg_req), 32'(exp_fwd));
    if (exp_fwd) begin
      chk("R3 dev", 32'(cfg_dev), 32'(m_addr[15:11]));
      chk("R3 reg", 32'(cfg_reg), 32'(m_addr[7:2]));
      chk("R3 be", 32'(cfg_be), w ? 32'(lanes(s, int'(l))) : 32'hF);
      if (w) begin
        for (int b = 0; b < 4; b++) be32[8*b +: 8] = {8{cfg_be[b]}};
        chk("R3 wdata", cfg_wdata & be32, (d << (8 * s)) & be32);
      end
    end
    @(negedge clk);
    req = 0;
    chk("R9 rvalid", 32'(rvalid), 32'(!w));
    if (!w) begin
      if (o < 4) v = m_addr;
      else if (o >= 8 || !exp_fwd) v = 32'hFFFF_FFFF;
      else v = dev_val(m_addr[15:11], m_addr[7:2]);
      chk({tag, " rdata"}, rdata, fmt(v, s, int'(l)));
    end else if (o < 4 && (l == 1 || l == 2 || l == 4) && fit(s, int'(l))) begin
      for (int b = s; b < s + int'(l); b++) m_addr[8*b +: 8] = d[8*(b-s) +: 8];
    end
  endtask

  function automatic logic [31:0] mk(logic e, logic [7:0] b, logic [4:0] dv, logic [2:0] f, logic [5:0] r);
    return {e, 7'h00, b, dv, f, r, 2'b00};
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 rvalid", 32'(rvalid), 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 cfg_req", 32'(cfg_req), 0);
    rst_n = 1;
    acc(0, 0, 4, 0);                         // R1 address register reads zero
    acc(0, 4, 4, 0);                         // R2 disabled out of reset
    acc(1, 4, 4, 32'h1234_5678);             // R2 write dropped
    acc(1, 0, 4, mk(1, 0, 3, 0, 5));         // R7 full write
    acc(0, 0, 4, 0);
    acc(0, 4, 4, 0);                         // R3 forwarded read
    acc(0, 5, 2, 0);                         // R8 halfword extract
    acc(0, 7, 1, 0);                         // R8 top byte
    acc(0, 6, 4, 0);                         // R8 crossing
    acc(0, 4, 0, 0);                         // R8 zero length
    acc(1, 5, 3, 32'h00AB_CDEF);             // R10 three lanes
    acc(1, 7, 2, 32'hFFFF);                  // R10 crossing write
    acc(0, 9, 4, 0);                         // R8 outside window
    acc(1, 12, 4, 32'hDEAD_BEEF);            // R10 outside window
    acc(1, 1, 1, 32'h0000_0040);             // R7 byte lane 1: dev 8
    acc(1, 2, 2, 32'h0000_0000);             // R7 halfword lanes 2,3: disable
    acc(0, 0, 4, 0);
    acc(1, 3, 1, 32'h80);                    // R7 enable via byte 3
    acc(1, 1, 3, 32'hFFFFFF);                // R7 length 3 ignored
    acc(1, 2, 4, 32'hFFFFFFFF);              // R7 crossing ignored
    acc(0, 0, 4, 0);
    acc(1, 0, 4, mk(1, 8'h01, 2, 0, 1));     // R4
    acc(0, 4, 4, 0);
    acc(1, 4, 4, 32'h1);
    acc(1, 0, 4, mk(1, 0, 2, 3, 1));         // R5
    acc(0, 4, 4, 0);
    acc(1, 4, 4, 32'h77);
    acc(1, 0, 4, mk(1, 0, 7, 0, 9));         // R6 absent slot
    acc(0, 4, 4, 0);
    acc(1, 6, 2, 32'h55AA);
    for (int i = 0; i < 1500; i++) begin
      int k = $urandom_range(0, 9);
      logic [2:0] l;
      case ($urandom_range(0, 7))
        0: l = 1; 1: l = 2; 2, 3, 4: l = 4; 5: l = 3; 6: l = 0; default: l = 5;
      endcase
      if (k < 3) begin
        logic [31:0] a = mk($urandom_range(0, 9) != 0,
                            ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h00,
                            5'($urandom), ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'h0,
                            6'($urandom));
        acc(1, 4'($urandom_range(0, 3)), l, a >> (8 * 0));
      end else begin
        logic [3:0] o = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'($urandom_range(0, 7));
        acc(k < 6, o, l, $urandom);
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule